// File: doc/BRIEF.md
# Fine-Scroll and Double-Height Slice Mapper

This block sits between the raster timing chain and the character generator of a text display. For each pixel row of a character row it takes the raster slice number and works out which slice of the glyph should be fetched. The result depends on two things. The first is the fine-scroll offset for the current frame, which applies only when the row lies in the scrolling region. The second is the row's height attributes.

Scrolling uses a biased 4-bit add. The first stage adds the scroll step to the raster slice. If that add does not carry, a second stage adds ten, modulo 16; if it carries, the second stage adds zero. A step of six therefore leaves every slice where it was, and each step above six moves the row content up by one slice. A carry out of the first stage means the fetched slice belongs to the following character row, and the block reports this on a wrap flag.

For double-height rows the scrolled slice is halved so that each glyph slice is shown twice. For the lower half of a double-height row, five is added after halving. The row attributes are latched by the row fetch logic and are held steady for the whole row. The output is registered once, so that it lines up with the character-code read.

Top module: `slice_mapper`

## Requirements
- R1: When row_in_region is 0, the scroll step input is ignored and an offset of 6 is used. For a plain row with raster slice s in 0..9, eff_slice equals s and row_wrap is 0.
- R2: When row_in_region is 1 with step k and the 4-bit sum s+k is below 16, eff_slice is (s+k+10) mod 16 (that is, s+k-6) and row_wrap is 0.
- R3: When s+k is 16 or more, eff_slice is s+k-16 and row_wrap is 1. For example, step 7 with slice 9 gives slice 0 with wrap.
- R4: row_wrap is 1 exactly when the first-stage add carries, and it is not affected by the height attributes.
- R5: When row_tall is 1 and row_lower is 0, eff_slice is the scrolled slice shifted right by one bit (0..9 map to 0,0,1,1,2,2,3,3,4,4).
- R6: When row_tall and row_lower are both 1, eff_slice is the halved slice plus 5 (0..9 map to 5,5,6,6,7,7,8,8,9,9).
- R7: When row_lower is 1 and row_tall is 0, row_lower has no effect: the scrolled slice passes through unchanged.
- R8: Outputs are registered. Inputs sampled at clock edge n appear at the outputs after that edge. While rst_n is low, eff_slice and row_wrap are 0.
- R9: Inside the scroll region, the step must lie in 6..15 when narrow_cols is 0 (10-slice rows) and in 6..14 when narrow_cols is 1 (9-slice rows).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raster_slice | input | 4 | Raster slice within the current character row |
| scroll_step | input | 4 | Per-frame fine-scroll step for rows in the region |
| narrow_cols | input | 1 | 1 selects the 132-column, 9-slice row mode |
| row_in_region | input | 1 | Latched attribute: row is inside the scrolling region |
| row_tall | input | 1 | Latched attribute: double-height row |
| row_lower | input | 1 | Latched attribute: lower half of a double-height row |
| eff_slice | output | 4 | Effective glyph slice, registered |
| row_wrap | output | 1 | Fetched slice belongs to the next character row, registered |

## Verification
On every cycle, the assertions check the following properties. A plain row outside the region passes its slice through and never wraps. A top-half tall row stays below slice 8 and a lower-half tall row stays within 5..12. The in-region step stays inside the legal range for the selected column mode. Only the bench scenarios can show the exact scrolled values for each step and slice. The same holds for the carry boundary, where step 7 with slice 9 lands on slice 0, and for the full halved and offset sequences. They also show that a lone lower-half bit is ignored and that the output appears one cycle late.

// File: rtl/slice_mapper.sv
module slice_mapper #(
  parameter int SW      = 4,
  parameter int NEUTRAL = 6,
  parameter int CORR    = 10,
  parameter int LOWOFS  = 5,
  parameter int MAXW    = 15,
  parameter int MAXN    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] raster_slice,
  input  logic [SW-1:0] scroll_step,
  input  logic          narrow_cols,
  input  logic          row_in_region,
  input  logic          row_tall,
  input  logic          row_lower,
  output logic [SW-1:0] eff_slice,
  output logic          row_wrap
);
  localparam logic [SW-1:0] NEUTRAL_V = SW'(NEUTRAL);
  localparam logic [SW-1:0] CORR_V    = SW'(CORR);
  localparam logic [SW-1:0] LOWOFS_V  = SW'(LOWOFS);

  logic [SW-1:0] step;
  logic [SW:0]   sum1;
  logic [SW-1:0] sum2, halved, mapped;

  assign step   = row_in_region ? scroll_step : NEUTRAL_V;
  assign sum1   = {1'b0, raster_slice} + {1'b0, step};
  assign sum2   = sum1[SW] ? sum1[SW-1:0] : sum1[SW-1:0] + CORR_V;
  assign halved = row_tall ? (sum2 >> 1) : sum2;
  assign mapped = (row_tall && row_lower) ? halved + LOWOFS_V : halved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_slice <= '0;
      row_wrap  <= 1'b0;
    end else begin
      eff_slice <= mapped;
      row_wrap  <= sum1[SW];
    end
  end

  // R1
  neutral_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_in_region && !row_tall && raster_slice < SW'(CORR))
      |=> (eff_slice == $past(raster_slice) && !row_wrap));

  // R5
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_tall && !row_lower) |=> (eff_slice < SW'(8)));

  // R6
  lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_tall && row_lower) |=> (eff_slice >= LOWOFS_V && eff_slice <= SW'(LOWOFS + 7)));

  // R9
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_in_region |-> (scroll_step >= NEUTRAL_V &&
                       scroll_step <= (narrow_cols ? SW'(MAXN) : SW'(MAXW))));
endmodule

// File: tb/test_slice_mapper.sv
module test_slice_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] raster_slice = '0, scroll_step = 4'd6;
  logic narrow_cols = 1'b0, row_in_region = 1'b0, row_tall = 1'b0, row_lower = 1'b0;
  logic [3:0] eff_slice;
  logic row_wrap;

  int vectors = 0, errors = 0;
  logic [3:0] q_slice[$];
  logic       q_wrap[$];
  string      q_tag[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  slice_mapper i_slice_mapper (
    .clk(clk), .rst_n(rst_n), .raster_slice(raster_slice), .scroll_step(scroll_step),
    .narrow_cols(narrow_cols), .row_in_region(row_in_region), .row_tall(row_tall),
    .row_lower(row_lower), .eff_slice(eff_slice), .row_wrap(row_wrap)
  );

  task automatic drive(input string tag, input int s, input int k, input bit nar,
                       input bit reg_in, input bit tall, input bit low);
    int kk, sum, e;
    bit w;
    @(negedge clk);
    raster_slice = 4'(s); scroll_step = 4'(k); narrow_cols = nar;
    row_in_region = reg_in; row_tall = tall; row_lower = low;
    kk  = reg_in ? k : 6;
    sum = s + kk;
    if (sum >= 16) begin e = sum - 16; w = 1'b1; end
    else begin e = (sum + 10) % 16; w = 1'b0; end
    if (tall) e = e / 2;
    if (tall && low) e = e + 5;
    q_slice.push_back(4'(e)); q_wrap.push_back(w); q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_slice.size() > 0) begin
      logic [3:0] es; logic ew; string t;
      es = q_slice.pop_front(); ew = q_wrap.pop_front(); t = q_tag.pop_front();
      vectors++;
      if (eff_slice !== es || row_wrap !== ew) begin
        errors++;
        $display("FAIL %s: got slice %0d wrap %0b, expected slice %0d wrap %0b",
                 t, eff_slice, row_wrap, es, ew);
      end
    end
  end

  initial begin
    #(8*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (eff_slice !== 4'd0 || row_wrap !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: got slice %0d wrap %0b, expected 0 0", eff_slice, row_wrap);
    end
    rst_n = 1'b1;
    // R1: outside region, step ignored (illegal step value on purpose)
    for (int s = 0; s < 10; s++) drive("R1", s, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    // R2 and R3 spot points
    drive("R2", 5, 6, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R2", 0, 7, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R3", 9, 7, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R3", 2, 14, 1'b1, 1'b1, 1'b0, 1'b0);
    // R2/R3 sweep, 80-column mode
    for (int k = 6; k <= 15; k++)
      for (int s = 0; s < 10; s++) drive((s + k >= 16) ? "R3" : "R2", s, k, 1'b0, 1'b1, 1'b0, 1'b0);
    // R2/R3 sweep, 132-column mode
    for (int k = 6; k <= 14; k++)
      for (int s = 0; s < 9; s++) drive((s + k >= 16) ? "R3" : "R2", s, k, 1'b1, 1'b1, 1'b0, 1'b0);
    // R5: upper half
    for (int s = 0; s < 10; s++) drive("R5", s, 6, 1'b0, 1'b0, 1'b1, 1'b0);
    // R6: lower half
    for (int s = 0; s < 10; s++) drive("R6", s, 6, 1'b0, 1'b0, 1'b1, 1'b1);
    // R4: wrap unaffected by height, scrolled tall rows
    for (int s = 0; s < 10; s++) drive("R4", s, 9, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int s = 0; s < 10; s++) drive("R4", s, 12, 1'b0, 1'b1, 1'b1, 1'b1);
    // R7: lower bit alone ignored
    for (int s = 0; s < 10; s++) drive("R7", s, 8, 1'b0, 1'b1, 1'b0, 1'b1);
    // R8: back-to-back changes, one-cycle latency
    drive("R8", 9, 7, 1'b0, 1'b1, 1'b0, 1'b0);
    drive("R8", 4, 6, 1'b0, 1'b0, 1'b1, 1'b1);
    drive("R8", 1, 15, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    row_in_region = 1'b0; row_tall = 1'b0; row_lower = 1'b0; raster_slice = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule